// File: doc/BRIEF.md
# Significand Rounding Unit

This unit is the last step of a floating-point datapath. It takes a normalised significand, the result sign, three raw extra bits (guard, round and sticky) and a two-bit rounding-mode select, and returns the significand rounded to its stored width. It also reports whether any precision was lost. When the rounding increment overflows an all-ones significand, it raises a flag that tells the caller to bump the exponent.

A postnormalisation input tells the unit whether the preceding operation needed a one-position left shift to normalise. When it did, the guard bit moves into the least significant position and the unit works with the round and sticky bits that remain. When it did not, the guard bit serves as the round bit and the other two are merged into the sticky bit. Four modes are selectable: nearest with ties to even, toward zero, toward positive infinity and toward negative infinity. Exponent range and denormal handling belong to the caller.

By default the results pass through one output register. A parameter removes that register and leaves a purely combinational path.

Top module: `sig_round_unit`

## Requirements
- R1: With `modeSel` = 2'b00 (nearest, ties to even), one ulp is added exactly when the effective round bit is 1 and at least one of the effective sticky bit and the least significant bit of the aligned significand is 1.
- R2: In mode 2'b00, a tie (effective round bit 1, effective sticky bit 0) increments only when the aligned least significant bit is 1, so the result always ends in 0.
- R3: With `modeSel` = 2'b01 (toward zero), the result is the aligned significand unchanged and `expInc` stays 0.
- R4: With `modeSel` = 2'b10 (toward positive infinity), one ulp is added only when `signIn` = 0 and the effective round or sticky bit is 1.
- R5: With `modeSel` = 2'b11 (toward negative infinity), one ulp is added only when `signIn` = 1 and the effective round or sticky bit is 1.
- R6: `inexact` is the OR of the effective round and sticky bits. When it is 0, the result equals the aligned significand in every mode.
- R7: With `postNorm` = 0, the aligned significand is `sigIn`, the effective round bit is `guardIn`, and the effective sticky bit is `roundIn` OR `stickyIn`.
- R8: With `postNorm` = 1, the aligned significand is `sigIn` shifted left by one with `guardIn` in bit 0, the effective round bit is `roundIn`, and the effective sticky bit is `stickyIn`.
- R9: When an increment carries out of an all-ones aligned significand, `sigOut` is a 1 in the top bit with all other bits 0, and `expInc` is 1. Otherwise `expInc` is 0.
- R10: With the default `REG_OUT` = 1, the outputs appear one clock after the inputs. While `rstN` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | SIG_W | Normalised significand before rounding |
| signIn | input | 1 | Result sign, 1 = negative |
| guardIn | input | 1 | First bit below the significand |
| roundIn | input | 1 | Second bit below the significand |
| stickyIn | input | 1 | OR of all lower bits |
| postNorm | input | 1 | 1 when a one-position left normalising shift is needed |
| modeSel | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sigOut | output | SIG_W | Rounded significand |
| inexact | output | 1 | Precision was lost |
| expInc | output | 1 | Rounding overflowed; the exponent must be incremented |

## Verification
In the default build, every result (`sigOut`, `inexact` and `expInc`) is due exactly one clock after the inputs that produce it, because only the output register lies between them. The bench applies each input vector on a falling edge, lets one rising edge capture it, and compares all three outputs on the next falling edge, so each comparison pairs a result with the vector that produced it. The embedded properties compare registered outputs against the previous cycle's aligned significand and inputs. A qualifier that becomes true one cycle after reset keeps them quiet during the first cycle.

// File: rtl/sig_round_pkg.sv
package sig_round_pkg;

  typedef enum logic [1:0] {
    MODE_NEAR_EVEN = 2'b00,
    MODE_TO_ZERO   = 2'b01,
    MODE_TO_POS    = 2'b10,
    MODE_TO_NEG    = 2'b11
  } roundMode_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic addUlp;
    logic inexact;
  } roundStrobes_t;

endpackage

// File: rtl/sig_round_align.sv
// Datapath front end: applies the optional one-position left shift and
// forms the effective round, sticky and lsb bits.
module sig_round_align #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0] sigIn,
  input  logic             guardIn,
  input  logic             roundIn,
  input  logic             stickyIn,
  input  logic             postNorm,
  output logic [SIG_W-1:0] alignedSig,
  output logic             rEff,
  output logic             sEff,
  output logic             lsbBit
);

  logic [SIG_W-1:0] shiftedSig;

  // With a shift, guard enters at bit 0 (R8).
  assign shiftedSig = {sigIn[SIG_W-2:0], guardIn};

  always_comb begin
    if (postNorm) begin
      alignedSig = shiftedSig;        // R8
      rEff       = roundIn;
      sEff       = stickyIn;
    end else begin
      alignedSig = sigIn;             // R7
      rEff       = guardIn;
      sEff       = roundIn | stickyIn;
    end
  end

  assign lsbBit = alignedSig[0];

endmodule

// File: rtl/sig_round_ctrl.sv
// Control: chooses whether to add one ulp for the selected mode.
module sig_round_ctrl
  import sig_round_pkg::*;
(
  input  logic [1:0]    modeSel,
  input  logic          signIn,
  input  logic          rEff,
  input  logic          sEff,
  input  logic          lsbBit,
  output roundStrobes_t strobes
);

  roundMode_e mode;
  logic       anyLost;

  assign mode    = roundMode_e'(modeSel);
  assign anyLost = rEff | sEff;

  always_comb begin
    strobes.inexact = anyLost;                     // R6
    unique case (mode)
      MODE_NEAR_EVEN: strobes.addUlp = rEff & (sEff | lsbBit);  // R1 R2
      MODE_TO_ZERO:   strobes.addUlp = 1'b0;                     // R3
      MODE_TO_POS:    strobes.addUlp = ~signIn & anyLost;        // R4
      MODE_TO_NEG:    strobes.addUlp = signIn & anyLost;         // R5
      default:        strobes.addUlp = 1'b0;
    endcase
  end

endmodule

// File: rtl/sig_round_incr.sv
// Datapath back end: increment and overflow handling.
module sig_round_incr
  import sig_round_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0] alignedSig,
  input  roundStrobes_t    strobes,
  output logic [SIG_W-1:0] roundedSig,
  output logic             carryOut
);

  localparam int SUM_W = SIG_W + 1;
  localparam logic [SIG_W-1:0] LEAD_ONE = {1'b1, {(SIG_W-1){1'b0}}};

  logic [SUM_W-1:0] sumWide;

  assign sumWide  = {1'b0, alignedSig} + {{SIG_W{1'b0}}, strobes.addUlp};
  assign carryOut = sumWide[SUM_W-1];

  // R9: an overflow leaves the new leading one and a zero fraction.
  assign roundedSig = carryOut ? LEAD_ONE : sumWide[SIG_W-1:0];

endmodule

// File: rtl/sig_round_unit.sv
// Top: align, control, increment, optional output register.
module sig_round_unit
  import sig_round_pkg::*;
#(
  parameter int SIG_W   = 24,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SIG_W-1:0] sigIn,
  input  logic             signIn,
  input  logic             guardIn,
  input  logic             roundIn,
  input  logic             stickyIn,
  input  logic             postNorm,
  input  logic [1:0]       modeSel,
  output logic [SIG_W-1:0] sigOut,
  output logic             inexact,
  output logic             expInc
);

  localparam logic [SIG_W-1:0] LEAD_ONE = {1'b1, {(SIG_W-1){1'b0}}};

  logic [SIG_W-1:0] alignedSig;
  logic             rEff;
  logic             sEff;
  logic             lsbBit;
  roundStrobes_t    strobes;
  logic [SIG_W-1:0] roundedSig;
  logic             carryOut;

  sig_round_align #(.SIG_W(SIG_W)) align_i (
    .sigIn      (sigIn),
    .guardIn    (guardIn),
    .roundIn    (roundIn),
    .stickyIn   (stickyIn),
    .postNorm   (postNorm),
    .alignedSig (alignedSig),
    .rEff       (rEff),
    .sEff       (sEff),
    .lsbBit     (lsbBit)
  );

  sig_round_ctrl ctrl_i (
    .modeSel (modeSel),
    .signIn  (signIn),
    .rEff    (rEff),
    .sEff    (sEff),
    .lsbBit  (lsbBit),
    .strobes (strobes)
  );

  sig_round_incr #(.SIG_W(SIG_W)) incr_i (
    .alignedSig (alignedSig),
    .strobes    (strobes),
    .roundedSig (roundedSig),
    .carryOut   (carryOut)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic pastValid;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sigOut    <= '0;            // R10
          inexact   <= 1'b0;
          expInc    <= 1'b0;
          pastValid <= 1'b0;
        end else begin
          sigOut    <= roundedSig;
          inexact   <= strobes.inexact;
          expInc    <= carryOut;
          pastValid <= 1'b1;
        end
      end

      AST_TIE_EVEN: assert property (@(posedge clk) disable iff (!rstN)
        (pastValid && $past(modeSel) == 2'b00 && $past(rEff) && !$past(sEff))
          |-> !sigOut[0]); // R2

      AST_TO_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (pastValid && $past(modeSel) == 2'b01)
          |-> (sigOut == $past(alignedSig) && !expInc)); // R3

      AST_POS_NEG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (pastValid && $past(modeSel) == 2'b10 && $past(signIn))
          |-> (sigOut == $past(alignedSig))); // R4

      AST_NEG_POS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (pastValid && $past(modeSel) == 2'b11 && !$past(signIn))
          |-> (sigOut == $past(alignedSig))); // R5

      AST_EXACT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (pastValid && !inexact)
          |-> (sigOut == $past(alignedSig) && !expInc)); // R6

      AST_CARRY_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
        (pastValid && expInc)
          |-> (sigOut == LEAD_ONE && $past(&alignedSig))); // R9
    end else begin : g_comb
      assign sigOut  = roundedSig;
      assign inexact = strobes.inexact;
      assign expInc  = carryOut;
    end
  endgenerate

endmodule

// File: tb/sig_round_unit_tb_top.sv
module sig_round_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SIG_W      = 24;
  localparam int N_RANDOM   = 2000;

  logic             clk = 1'b0;
  logic             rstN;
  logic [SIG_W-1:0] sigIn;
  logic             signIn, guardIn, roundIn, stickyIn, postNorm;
  logic [1:0]       modeSel;
  logic [SIG_W-1:0] sigOut;
  logic             inexact, expInc;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_round_unit #(.SIG_W(SIG_W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .signIn(signIn),
    .guardIn(guardIn), .roundIn(roundIn), .stickyIn(stickyIn),
    .postNorm(postNorm), .modeSel(modeSel),
    .sigOut(sigOut), .inexact(inexact), .expInc(expInc)
  );

  // Expected {sig, inexact, expInc} from the requirements.
  function automatic logic [SIG_W+1:0] refRound(
    input logic [SIG_W-1:0] s, input logic sg, g, r, st, pn,
    input logic [1:0] m);
    logic [SIG_W-1:0] al;
    logic [SIG_W:0]   sum;
    logic rb, sb, inc, cy;
    al = pn ? {s[SIG_W-2:0], g} : s;       // R7 R8
    rb = pn ? r : g;
    sb = pn ? st : (r | st);
    case (m)
      2'b00:   inc = rb & (sb | al[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = !sg & (rb | sb);
      default: inc = sg & (rb | sb);
    endcase
    sum = {1'b0, al} + {{SIG_W{1'b0}}, inc};
    cy  = sum[SIG_W];
    return {cy ? {1'b1, {(SIG_W-1){1'b0}}} : sum[SIG_W-1:0], rb | sb, cy};
  endfunction

  task automatic runVec(input logic [SIG_W-1:0] s, input logic sg, g, r, st, pn,
                        input logic [1:0] m, input string tag);
    logic [SIG_W+1:0] exp;
    sigIn = s; signIn = sg; guardIn = g; roundIn = r; stickyIn = st;
    postNorm = pn; modeSel = m;
    exp = refRound(s, sg, g, r, st, pn, m);
    @(negedge clk);
    checks++;
    if ({sigOut, inexact, expInc} !== exp) begin
      errors++;
      $display("FAIL %s: got sig=%h inexact=%b expInc=%b, expected sig=%h inexact=%b expInc=%b",
               tag, sigOut, inexact, expInc, exp[SIG_W+1:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SIG_W-1:0] rs;
    logic [1:0] rm;
    string tags [4];
    tags[0] = "R1"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
    rstN = 1'b0; sigIn = 24'h9ABCDE; signIn = 1'b0; guardIn = 1'b1;
    roundIn = 1'b1; stickyIn = 1'b1; postNorm = 1'b0; modeSel = 2'b00;
    repeat (3) @(negedge clk);
    // R10: outputs held at zero in reset
    checks++;
    if ({sigOut, inexact, expInc} !== '0) begin
      errors++;
      $display("FAIL R10: got %h/%b/%b, expected 0/0/0", sigOut, inexact, expInc);
    end
    rstN = 1'b1;

    // Directed corners
    runVec(24'h800002, 0, 1, 0, 0, 0, 2'b00, "R2 tie even stays");
    runVec(24'h800003, 0, 1, 0, 0, 0, 2'b00, "R2 tie odd goes up");
    runVec(24'h800002, 0, 1, 1, 0, 0, 2'b00, "R1 above half");
    runVec(24'h800002, 0, 0, 1, 1, 0, 2'b00, "R1 below half");
    runVec(24'hC00001, 1, 1, 1, 1, 0, 2'b01, "R3 toward zero drops bits");
    runVec(24'h800000, 0, 0, 0, 1, 0, 2'b10, "R4 positive sticky only");
    runVec(24'h800000, 1, 1, 1, 1, 0, 2'b10, "R4 negative unchanged");
    runVec(24'h800000, 1, 0, 0, 1, 0, 2'b11, "R5 negative sticky only");
    runVec(24'h800000, 0, 1, 1, 1, 0, 2'b11, "R5 positive unchanged");
    for (int mm = 0; mm < 4; mm++)
      runVec(24'hFFFFFF, mm[0], 0, 0, 0, 0, mm[1:0], "R6 exact all modes");
    runVec(24'h800000, 0, 0, 1, 0, 0, 2'b10, "R7 round folds into sticky");
    runVec(24'h800001, 0, 0, 1, 0, 0, 2'b00, "R7 round bit not used as R");
    runVec(24'h400001, 0, 1, 0, 0, 1, 2'b01, "R8 shifted guard becomes lsb");
    runVec(24'h400001, 0, 1, 1, 0, 1, 2'b00, "R8 shifted tie on odd lsb");
    runVec(24'h400000, 0, 0, 1, 0, 1, 2'b00, "R8 shifted tie on even lsb");
    runVec(24'hFFFFFF, 0, 1, 1, 0, 0, 2'b00, "R9 overflow nearest");
    runVec(24'hFFFFFF, 1, 0, 0, 1, 0, 2'b11, "R9 overflow toward neg");
    runVec(24'h7FFFFF, 0, 1, 0, 1, 1, 2'b10, "R9 overflow after shift");

    // Constrained random
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < N_RANDOM; i++) begin
      rs = SIG_W'($urandom);
      if (($urandom % 8) == 0) rs = '1;
      else if (($urandom % 2) == 1) rs[SIG_W-1] = 1'b1;
      rm = 2'($urandom);
      runVec(rs, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), rm, tags[rm]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule